// File: doc/BRIEF.md
# Programmable Flag Offset Loader

This block holds the two offset values that a FIFO's programmable flags are compared against: one for the almost-empty flag and one for the almost-full flag. It does not generate the flags. It keeps the two offsets, makes them visible on its outputs at all times, and lets software-side logic change them or read them back after a master reset.

While master reset is held, the block samples three configuration pins on every write-clock edge: the load-enable pin and a two-bit select. Together they choose one of eight default offsets, which are loaded into both registers. The load-enable level alone also fixes the programming method until the next reset. After reset, pulling load enable low opens a programming window. In serial mode, each write-clock edge with the serial enable also low shifts one bit in. In parallel mode, a write strobe stores the data bus into the register under an internal pointer. Parallel readback works in both modes.

The window is managed by a three-state machine. `ST_IDLE` means the window was closed on the last edge. `ST_PTR_AE` and `ST_PTR_AF` mean the window is open and the next parallel access goes to the almost-empty or the almost-full register. The transitions are as follows. *open* goes from `ST_IDLE` to `ST_PTR_AE`, or to `ST_PTR_AF` when the opening edge already carries an access. *advance* goes from `ST_PTR_AE` to `ST_PTR_AF`, and *wrap* goes from `ST_PTR_AF` back to `ST_PTR_AE`; both happen on an access edge. *close* goes from any state to `ST_IDLE` on an edge with load enable high. Master reset forces `ST_IDLE`.

Top module: `flag_offset_loader`

## Requirements
- R1: On the edges where `mrst_n` is low, both `ae_off` and `af_off` take the default value. The default is a run of ones in the low bits, of length 2*`fsel`+`ld_n`+1, clipped to the offset width: (2^(2*fsel+ld_n+1))-1 for width 8. At the same time, `rd_data` clears to 0.
- R2: The level of `ld_n` on the last edge with `mrst_n` low sets the method until the next reset. A 1 selects serial and a 0 selects parallel.
- R3: In serial mode, an edge with `ld_n`=0 and `sen_n`=0 shifts the pair {af_off, ae_off} right by one, with `sdi` entering the top bit of `af_off`. After 2*W such edges, the first bits shifted in fill `ae_off` LSB first, and the remaining bits then fill `af_off` LSB first.
- R4: An edge with `sen_n`=1 or `ld_n`=1 does not shift. Both offsets keep their contents.
- R5: In parallel mode, an edge with `ld_n`=0 and `pwr_n`=0 stores `pdata_in` in the pointed register. The pointer then toggles, so successive writes go to almost-empty, almost-full, almost-empty and so on.
- R6: In serial mode, parallel write strobes change neither register nor the pointer. In parallel mode, `sen_n`/`sdi` shifting has no effect.
- R7: In either mode, an edge with `ld_n`=0 and `prd_n`=0 loads the pointed register into `rd_data` and toggles the pointer. Otherwise `rd_data` holds.
- R8: Any edge with `ld_n`=1 returns the pointer to the almost-empty register.
- R9: With `ld_n`=1, the `pwr_n` and `prd_n` strobes change neither offset nor `rd_data`.
- R10: A parallel-mode edge with both `pwr_n` and `prd_n` low returns the register's previous value in `rd_data` and stores `pdata_in`. The pointer advances only once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock; all state changes on its rising edge |
| mrst_n | input | 1 | Master reset, active low, synchronous |
| ld_n | input | 1 | During reset: default/method select; afterwards: access window enable, active low |
| fsel | input | 2 | Default offset select, sampled during reset |
| sen_n | input | 1 | Serial shift enable, active low |
| sdi | input | 1 | Serial data bit |
| pwr_n | input | 1 | Parallel write strobe, active low |
| prd_n | input | 1 | Parallel read strobe, active low |
| pdata_in | input | W | Parallel write data |
| ae_off | output | W | Current almost-empty offset |
| af_off | output | W | Current almost-full offset |
| rd_data | output | W | Last value read back |

## Verification
The hardest case to reach is the pointer's position inside an open window: after a single write, after a window that closed halfway through, and after an edge that both reads and writes. The position never appears on a port. The stimulus therefore writes one register, closes the window and writes again, then reads both registers back. The only way this readback comes out in the expected order is if the pointer followed R5, R8 and R10. All eight reset configurations are swept. In each one, both methods are attempted, so the rejected method is seen to leave the registers unchanged. Parallel mode also runs a full sweep of data values.

// File: rtl/flag_offset_pkg.sv
package flag_offset_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_PTR_AE = 2'd1,
        ST_PTR_AF = 2'd2
    } ptr_state_e;

    typedef enum logic {
        LOAD_PARALLEL = 1'b0,
        LOAD_SERIAL   = 1'b1
    } load_mode_e;

endpackage

// File: rtl/fol_default.sv
module fol_default #(
    parameter int W = 8
) (
    input  logic         ld_n,
    input  logic [1:0]   fsel,
    output logic [W-1:0] dflt
);
    localparam int LW = 4;

    logic [LW-1:0] run_len;

    always_comb begin
        run_len = {1'b0, fsel, 1'b0} + {3'b000, ld_n} + 4'd1;
    end

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign dflt[i] = (i < int'(run_len));
    end
endmodule

// File: rtl/fol_ctrl.sv
module fol_ctrl
    import flag_offset_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ld_n,
    input  logic       sen_n,
    input  logic       pwr_n,
    input  logic       prd_n,
    output load_mode_e mode,
    output logic       shift_en,
    output logic       wr_en,
    output logic       rd_en,
    output logic       sel_af
);
    ptr_state_e state, state_nx;
    logic       win;
    logic       access;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode <= ld_n ? LOAD_SERIAL : LOAD_PARALLEL;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        win      = rst_n & ~ld_n;
        shift_en = win & (mode == LOAD_SERIAL) & ~sen_n;
        wr_en    = win & (mode == LOAD_PARALLEL) & ~pwr_n;
        rd_en    = win & ~prd_n;
        access   = wr_en | rd_en;
        sel_af   = (state == ST_PTR_AF);
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (!ld_n) begin
                    state_nx = access ? ST_PTR_AF : ST_PTR_AE;
                end
            end
            ST_PTR_AE: begin
                if (ld_n) begin
                    state_nx = ST_IDLE;
                end else if (access) begin
                    state_nx = ST_PTR_AF;
                end
            end
            ST_PTR_AF: begin
                if (ld_n) begin
                    state_nx = ST_IDLE;
                end else if (access) begin
                    state_nx = ST_PTR_AE;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // R8: a closed window always leaves the pointer on almost-empty
    p_ptr_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ld_n |=> (state == ST_IDLE));

    // R5: an access while pointing at almost-empty moves to almost-full
    p_ptr_advance_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PTR_AE && !ld_n && (wr_en || rd_en)) |=> (state == ST_PTR_AF));

    // R2: the method never changes outside reset
    p_mode_fixed_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> $stable(mode));
endmodule

// File: rtl/fol_store.sv
module fol_store #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] dflt,
    input  logic         shift_en,
    input  logic         wr_en,
    input  logic         rd_en,
    input  logic         sel_af,
    input  logic         sdi,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] ae_off,
    output logic [W-1:0] af_off,
    output logic [W-1:0] rd_data
);
    localparam int PW = 2 * W;

    logic [PW-1:0] pair;
    logic [W-1:0]  pointed;

    always_comb begin
        pointed = sel_af ? pair[PW-1:W] : pair[W-1:0];
        ae_off  = pair[W-1:0];
        af_off  = pair[PW-1:W];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pair    <= {dflt, dflt};
            rd_data <= '0;
        end else begin
            if (shift_en) begin
                pair <= {sdi, pair[PW-1:1]};
            end else if (wr_en) begin
                if (sel_af) begin
                    pair[PW-1:W] <= wdata;
                end else begin
                    pair[W-1:0] <= wdata;
                end
            end
            if (rd_en) begin
                rd_data <= pointed;
            end
        end
    end

    // R4: without a shift or a write the offsets do not move
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift_en && !wr_en) |=> $stable(pair));

    // R7: a read returns what the pointer selected on that edge
    p_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> (rd_data == $past(sel_af ? af_off : ae_off)));

    // R7: no read, no change of the readback register
    p_rd_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));
endmodule

// File: rtl/flag_offset_loader.sv
module flag_offset_loader
    import flag_offset_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         wclk,
    input  logic         mrst_n,
    input  logic         ld_n,
    input  logic [1:0]   fsel,
    input  logic         sen_n,
    input  logic         sdi,
    input  logic         pwr_n,
    input  logic         prd_n,
    input  logic [W-1:0] pdata_in,
    output logic [W-1:0] ae_off,
    output logic [W-1:0] af_off,
    output logic [W-1:0] rd_data
);
    load_mode_e   mode;
    logic         shift_en;
    logic         wr_en;
    logic         rd_en;
    logic         sel_af;
    logic [W-1:0] dflt;

    fol_default #(.W(W)) u_default (
        .ld_n (ld_n),
        .fsel (fsel),
        .dflt (dflt)
    );

    fol_ctrl u_ctrl (
        .clk      (wclk),
        .rst_n    (mrst_n),
        .ld_n     (ld_n),
        .sen_n    (sen_n),
        .pwr_n    (pwr_n),
        .prd_n    (prd_n),
        .mode     (mode),
        .shift_en (shift_en),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .sel_af   (sel_af)
    );

    fol_store #(.W(W)) u_store (
        .clk      (wclk),
        .rst_n    (mrst_n),
        .dflt     (dflt),
        .shift_en (shift_en),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .sel_af   (sel_af),
        .sdi      (sdi),
        .wdata    (pdata_in),
        .ae_off   (ae_off),
        .af_off   (af_off),
        .rd_data  (rd_data)
    );

    // R6: the two write methods never act on the same edge
    p_one_method_r6: assert property (@(posedge wclk) disable iff (!mrst_n)
        (mode == LOAD_SERIAL) |-> !wr_en);
endmodule

// File: tb/flag_offset_loader_tb.sv
module flag_offset_loader_tb;
    localparam int W = 8;

    logic         wclk = 1'b0;
    logic         mrst_n = 1'b0;
    logic         ld_n = 1'b1;
    logic [1:0]   fsel = 2'd0;
    logic         sen_n = 1'b1;
    logic         sdi = 1'b0;
    logic         pwr_n = 1'b1;
    logic         prd_n = 1'b1;
    logic [W-1:0] pdata_in = '0;
    logic [W-1:0] ae_off, af_off, rd_data;

    int checks = 0;
    int failures = 0;

    always #5 wclk = ~wclk;

    flag_offset_loader #(.W(W)) u_dut (
        .wclk(wclk), .mrst_n(mrst_n), .ld_n(ld_n), .fsel(fsel),
        .sen_n(sen_n), .sdi(sdi), .pwr_n(pwr_n), .prd_n(prd_n),
        .pdata_in(pdata_in), .ae_off(ae_off), .af_off(af_off), .rd_data(rd_data)
    );

    task automatic step();
        @(posedge wclk);
        @(negedge wclk);
    endtask

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle_pins();
        ld_n = 1'b1; sen_n = 1'b1; pwr_n = 1'b1; prd_n = 1'b1; sdi = 1'b0;
    endtask

    task automatic do_reset(input logic l, input logic [1:0] f);
        idle_pins();
        mrst_n = 1'b0; ld_n = l; fsel = f;
        step(); step();
        mrst_n = 1'b1; ld_n = 1'b1;
        step();
    endtask

    task automatic pwrite(input logic [W-1:0] v);
        ld_n = 1'b0; pwr_n = 1'b0; pdata_in = v;
        step();
        pwr_n = 1'b1;
    endtask

    task automatic close_win();
        idle_pins();
        step();
    endtask

    task automatic read_pair(input string req, input logic [W-1:0] eae, input logic [W-1:0] eaf);
        ld_n = 1'b0; prd_n = 1'b0;
        step();
        chk(req, rd_data, eae);
        step();
        chk(req, rd_data, eaf);
        prd_n = 1'b1;
        step();
        chk(req, rd_data, eaf);
        close_win();
    endtask

    function automatic logic [W-1:0] dflt_of(input int l, input int f);
        int len = 2 * f + l + 1;
        if (len > W) len = W;
        return W'((1 << len) - 1);
    endfunction

    initial begin
        logic [2*W-1:0] model;
        logic [W-1:0] e0, e1, tmp;
        for (int c = 0; c < 8; c++) begin
            logic l;
            logic [1:0] f;
            l = c[2];
            f = c[1:0];
            do_reset(l, f);
            e0 = dflt_of(int'(l), int'(f));
            chk("R1 ae default", ae_off, e0);
            chk("R1 af default", af_off, e0);
            chk("R1 rd_data reset", rd_data, '0);

            // method probe: parallel write
            pwrite(8'hA5);
            close_win();
            chk("R2/R6 ae after pwrite", ae_off, l ? e0 : 8'hA5);
            chk("R2/R6 af after pwrite", af_off, e0);
            model = {af_off, ae_off};

            // method probe: serial shift of five ones
            ld_n = 1'b0; sen_n = 1'b0; sdi = 1'b1;
            for (int k = 0; k < 5; k++) begin
                step();
                if (l) model = {1'b1, model[2*W-1:1]};
            end
            close_win();
            chk("R2/R6 ae after shift", ae_off, model[W-1:0]);
            chk("R2/R6 af after shift", af_off, model[2*W-1:W]);

            if (l) begin
                e0 = W'(c * 37 + 3);
                e1 = ~W'(c * 29);
                model = {e1, e0};
                ld_n = 1'b0; sen_n = 1'b0;
                for (int k = 0; k < 2 * W; k++) begin
                    sdi = model[k];
                    step();
                end
                close_win();
                chk("R3 serial ae", ae_off, e0);
                chk("R3 serial af", af_off, e1);
                read_pair("R7 serial readback", e0, e1);
                // R4: sen_n high with window open, then window closed with sen_n low
                ld_n = 1'b0; sen_n = 1'b1; sdi = 1'b1;
                step(); step(); step();
                ld_n = 1'b1; sen_n = 1'b0;
                step(); step();
                close_win();
                chk("R4 ae hold", ae_off, e0);
                chk("R4 af hold", af_off, e1);
                // R4: gapped shifting
                model = {af_off, ae_off};
                for (int k = 0; k < 6; k++) begin
                    ld_n = 1'b0; sen_n = k[0]; sdi = k[1];
                    step();
                    if (!k[0]) model = {k[1], model[2*W-1:1]};
                end
                close_win();
                chk("R4 gapped ae", ae_off, model[W-1:0]);
                chk("R4 gapped af", af_off, model[2*W-1:W]);
            end else begin
                // R5 sweep of all data values
                for (int v = 0; v < 256; v++) begin
                    ld_n = 1'b0; pwr_n = 1'b0;
                    pdata_in = W'(v);
                    step();
                    pdata_in = W'(v) ^ 8'h5A;
                    step();
                    close_win();
                    chk("R5 ae write", ae_off, W'(v));
                    chk("R5 af write", af_off, W'(v) ^ 8'h5A);
                end
                read_pair("R7 parallel readback", 8'hFF, 8'hFF ^ 8'h5A);
                // R8: window closed after one write resets the pointer
                pwrite(8'h11);
                close_win();
                pwrite(8'h22);
                close_win();
                chk("R8 ae rewrite", ae_off, 8'h22);
                chk("R8 af untouched", af_off, 8'hFF ^ 8'h5A);
                e1 = af_off;
                // R9: strobes with window closed
                tmp = rd_data;
                ld_n = 1'b1; pwr_n = 1'b0; prd_n = 1'b0; pdata_in = 8'h77;
                step(); step();
                close_win();
                chk("R9 ae", ae_off, 8'h22);
                chk("R9 af", af_off, e1);
                chk("R9 rd_data", rd_data, tmp);
                // R10: simultaneous read and write
                ld_n = 1'b0; pwr_n = 1'b0; prd_n = 1'b0; pdata_in = 8'h3C;
                step();
                chk("R10 old value read", rd_data, 8'h22);
                chk("R10 ae stored", ae_off, 8'h3C);
                pwr_n = 1'b1;
                step();
                chk("R10 single advance", rd_data, e1);
                close_win();
                chk("R10 af untouched", af_off, e1);
            end
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge wclk);
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule